// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns a 32-bit bus address into one of six active-low chip selects. Each region has a base register and a mask register, and software reaches both through a word-wide register port. A region matches when the address equals its base on every bit that its mask does not exclude. Each region also carries a non-cacheable flag and a data-bus-width code. For every valid access the block reports which region won, that region's width code, and whether the access may be cached.

Region 0 serves the boot ROM. It is live from reset, its base is pinned at address zero, and its width code is fixed by a parameter. Regions 1 to 5 decode nothing until software has written both their base register and their mask register. Keeping regions apart is left to software. If regions do overlap, the lowest-numbered matching region wins, so at most one select is ever active.

The address phase (`bus_valid`, `bus_addr`) is captured on a clock edge. The selects and attributes are decoded combinationally from that captured phase.

Top module: `csdec_top`

## Requirements
- R1: A bus address presented with `bus_valid` high is decoded in the cycle after the clock edge that captures it. A cycle whose captured `bus_valid` was low drives all `cs_n` high, `hit` low, and `sel_idx`, `sel_bw` and `sel_cacheable` to 0.
- R2: Region i matches when `bus_addr[31:4]` equals base bits [31:4] on every bit position whose mask bit is 0. Address bits [3:0] never take part in the comparison.
- R3: The register map uses a 6-bit byte offset. The base register of region i sits at 8*i and its mask register at 8*i+4. Base register layout: [31:4] base, [3] reads 0, [2:1] width code, [0] non-cacheable flag. Mask register layout: [31:4] mask, [3:0] read 0. `reg_rdata` returns the addressed register combinationally.
- R4: Regions 1 to 5 never match until both their base register and their mask register have been written at least once since reset. Writing only one of the two leaves the select inactive.
- R5: When several regions match, only the lowest-numbered one is selected. At most one `cs_n` bit is ever low.
- R6: When no region matches a valid access, `hit` is 0, all `cs_n` bits are 1, and `sel_idx`, `sel_bw` and `sel_cacheable` are 0.
- R7: On a hit, `sel_idx` is the winning region's number and `sel_bw` is its width code. `sel_cacheable` is the inverse of its non-cacheable flag.
- R8: Region 0 is live from reset. Its base always reads 0, and writes to its base field are ignored. Its width code always reads `ROM_BW` (default 2). Its non-cacheable flag resets to 1 and can be written. Its mask resets to `ROM_MASK` (default 0xFFF in bits [31:4], a 64 KiB window) and can be written.
- R9: A register write whose offset has bits [1:0] non-zero, or whose offset lies at 48 or above, changes no register. Reads at such offsets return 0.
- R10: Reset returns regions 1 to 5 to all-zero registers and clears their written status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Address phase valid |
| bus_addr | input | 32 | Bus address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_ofs | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| cs_n | output | 6 | Active-low chip selects |
| hit | output | 1 | Some region matched |
| sel_idx | output | 3 | Winning region number |
| sel_bw | output | 2 | Winning region width code |
| sel_cacheable | output | 1 | Winning region may be cached |

## Verification
The hardest situation to reach is a region that is half-programmed, because the decoder must stay silent even though the address compares equal. The stimulus gets there from both sides. One region gets only its base written and is then probed inside its window. Another gets only its mask written and is probed the same way. Reset is then applied in the middle of the run, and a previously working window is probed again, so the written status is seen to clear. A deliberate overlap between two regions exercises the priority rule.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
    localparam int ADDR_W    = 32;
    localparam int NUM_CS    = 6;
    localparam int CMP_LSB   = 4;
    localparam int BW_W      = 2;
    localparam int CMP_W     = ADDR_W - CMP_LSB;
    localparam int IDX_W     = $clog2(NUM_CS);
    localparam int REG_OFS_W = $clog2(NUM_CS) + 3;
    localparam int PAD_W     = CMP_LSB - 1 - BW_W;

    typedef struct packed {
        logic [CMP_W-1:0] base;
        logic [CMP_W-1:0] mask;
        logic [BW_W-1:0]  bw;
        logic             nc;
        logic             base_wr;
        logic             mask_wr;
    } region_t;
endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
    import csdec_pkg::*;
#(
    parameter logic [CMP_W-1:0] ROM_MASK = CMP_W'(28'h0000FFF),
    parameter logic [BW_W-1:0]  ROM_BW   = 2'd2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [REG_OFS_W-1:0]         ofs,
    input  logic [ADDR_W-1:0]            wdata,
    output logic [ADDR_W-1:0]            rdata,
    output region_t [NUM_CS-1:0]         rgn_o
);
    typedef struct packed {
        region_t [NUM_CS-1:0] rgn;
    } regs_state_t;

    regs_state_t st_d, st_q, st_rst;

    logic [REG_OFS_W-4:0] ofs_idx;
    logic                 ofs_mask, ofs_ok;

    always_comb begin
        ofs_idx  = ofs[REG_OFS_W-1:3];
        ofs_mask = ofs[2];
        ofs_ok   = (ofs[1:0] == 2'b00) && (int'(ofs_idx) < NUM_CS);
    end

    always_comb begin
        st_rst = '0;
        st_rst.rgn[0].mask    = ROM_MASK;
        st_rst.rgn[0].bw      = ROM_BW;
        st_rst.rgn[0].nc      = 1'b1;
        st_rst.rgn[0].base_wr = 1'b1;
        st_rst.rgn[0].mask_wr = 1'b1;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CS; i++) begin
            if (wr_en && ofs_ok && int'(ofs_idx) == i) begin
                if (ofs_mask) begin
                    st_d.rgn[i].mask    = wdata[ADDR_W-1:CMP_LSB];
                    st_d.rgn[i].mask_wr = 1'b1;
                end else begin
                    st_d.rgn[i].base    = (i == 0) ? '0 : wdata[ADDR_W-1:CMP_LSB];
                    st_d.rgn[i].bw      = (i == 0) ? ROM_BW : wdata[BW_W:1];
                    st_d.rgn[i].nc      = wdata[0];
                    st_d.rgn[i].base_wr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (ofs_ok && int'(ofs_idx) == i) begin
                if (ofs_mask) rdata = {st_q.rgn[i].mask, {CMP_LSB{1'b0}}};
                else          rdata = {st_q.rgn[i].base, {PAD_W{1'b0}},
                                       st_q.rgn[i].bw, st_q.rgn[i].nc};
            end
        end
    end

    assign rgn_o = st_q.rgn;

    for (genvar g = 1; g < NUM_CS; g++) begin : g_sticky
        a_r4_written_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.rgn[g].base_wr && st_q.rgn[g].mask_wr) |=>
            (st_q.rgn[g].base_wr && st_q.rgn[g].mask_wr))
            else $error("R4 written status dropped");
    end

    a_r8_rom_base_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == '0) |-> (rdata[ADDR_W-1:CMP_LSB] == '0))
        else $error("R8 region 0 base not zero");
endmodule

// File: rtl/csdec_match.sv
module csdec_match
    import csdec_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 vld,
    input  region_t [NUM_CS-1:0] rgn,
    output logic [NUM_CS-1:0]    match
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
        logic armed;
        logic same;
        if (g == 0) begin : g_rom
            assign armed = 1'b1;
        end else begin : g_prog
            assign armed = rgn[g].base_wr && rgn[g].mask_wr;
        end
        assign same     = ((addr[ADDR_W-1:CMP_LSB] ^ rgn[g].base) & ~rgn[g].mask) == '0;
        assign match[g] = vld && armed && same;
    end
endmodule

// File: rtl/csdec_prio.sv
module csdec_prio
    import csdec_pkg::*;
(
    input  logic [NUM_CS-1:0]    match,
    input  region_t [NUM_CS-1:0] rgn,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx,
    output logic [BW_W-1:0]      bw,
    output logic                 cacheable,
    output logic [NUM_CS-1:0]    cs_n
);
    always_comb begin
        hit       = |match;
        idx       = '0;
        bw        = '0;
        cacheable = 1'b0;
        cs_n      = '1;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx       = IDX_W'(i);
                bw        = rgn[i].bw;
                cacheable = !rgn[i].nc;
            end
        end
        if (hit) cs_n[idx] = 1'b0;
    end
endmodule

// File: rtl/csdec_top.sv
module csdec_top
    import csdec_pkg::*;
#(
    parameter logic [CMP_W-1:0] ROM_MASK = CMP_W'(28'h0000FFF),
    parameter logic [BW_W-1:0]  ROM_BW   = 2'd2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 reg_wr_en,
    input  logic [REG_OFS_W-1:0] reg_ofs,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata,
    output logic [NUM_CS-1:0]    cs_n,
    output logic                 hit,
    output logic [IDX_W-1:0]     sel_idx,
    output logic [BW_W-1:0]      sel_bw,
    output logic                 sel_cacheable
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              vld;
    } phase_t;

    phase_t ph_d, ph_q;
    region_t [NUM_CS-1:0] rgn;
    logic [NUM_CS-1:0]    match;

    always_comb begin
        ph_d.addr = bus_addr;
        ph_d.vld  = bus_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    csdec_regs #(.ROM_MASK(ROM_MASK), .ROM_BW(ROM_BW)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .ofs   (reg_ofs),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .rgn_o (rgn)
    );

    csdec_match match_i (
        .addr  (ph_q.addr),
        .vld   (ph_q.vld),
        .rgn   (rgn),
        .match (match)
    );

    csdec_prio prio_i (
        .match     (match),
        .rgn       (rgn),
        .hit       (hit),
        .idx       (sel_idx),
        .bw        (sel_bw),
        .cacheable (sel_cacheable),
        .cs_n      (cs_n)
    );

    a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n))
        else $error("R5 more than one select");

    a_r6_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (cs_n == '1 && sel_idx == '0 && !sel_cacheable))
        else $error("R6 outputs active on miss");

    a_r1_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(bus_valid))
        else $error("R1 hit without valid phase");

    a_r5_rom_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (match[0] && hit) |-> (sel_idx == '0 && !cs_n[0]))
        else $error("R5 region 0 lost priority");
endmodule

// File: tb/csdec_top_tb_top.sv
module csdec_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_ofs = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  cs_n;
    logic        hit;
    logic [2:0]  sel_idx;
    logic [1:0]  sel_bw;
    logic        sel_cacheable;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural model state
    logic [31:0] m_base [6];
    logic [31:0] m_mask [6];
    int          m_bw [6];
    int          m_nc [6];
    bit          m_bs [6];
    bit          m_ms [6];

    always #5 clk = ~clk;

    csdec_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .reg_wr_en(reg_wr_en), .reg_ofs(reg_ofs), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cs_n(cs_n), .hit(hit), .sel_idx(sel_idx),
        .sel_bw(sel_bw), .sel_cacheable(sel_cacheable)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 6; i++) begin
            m_base[i] = 0; m_mask[i] = 0; m_bw[i] = 0; m_nc[i] = 0;
            m_bs[i] = 0; m_ms[i] = 0;
        end
        m_mask[0] = 32'h0000_FFF0; m_bw[0] = 2; m_nc[0] = 1; m_bs[0] = 1; m_ms[0] = 1;
    endtask

    function automatic logic [31:0] model_read(input int ofs);
        int r = ofs / 8;
        if (ofs % 4 != 0 || r >= 6) return 0;
        if (ofs % 8 == 4) return m_mask[r];
        return m_base[r] | (m_bw[r] * 2) | m_nc[r];
    endfunction

    task automatic model_write(input int ofs, input logic [31:0] d);
        int r = ofs / 8;
        if (ofs % 4 != 0 || r >= 6) return;
        if (ofs % 8 == 4) begin
            m_mask[r] = d & 32'hFFFF_FFF0; m_ms[r] = 1;
        end else begin
            m_base[r] = (r == 0) ? 0 : (d & 32'hFFFF_FFF0);
            m_bw[r]   = (r == 0) ? 2 : int'((d >> 1) & 3);
            m_nc[r]   = int'(d & 1);
            m_bs[r]   = 1;
        end
    endtask

    task automatic expect_outputs(input string tag, input bit v, input logic [31:0] a);
        int win = -1;
        if (v) begin
            for (int r = 5; r >= 0; r--) begin
                if (m_bs[r] && m_ms[r] &&
                    (((a ^ m_base[r]) & ~m_mask[r] & 32'hFFFF_FFF0) == 0)) win = r;
            end
        end
        if (win < 0) begin
            check(tag, {31'd0, hit}, 0, "hit");
            check(tag, {26'd0, cs_n}, 32'h3F, "cs_n");
            check(tag, {29'd0, sel_idx}, 0, "sel_idx");
            check(tag, {30'd0, sel_bw}, 0, "sel_bw");
            check(tag, {31'd0, sel_cacheable}, 0, "sel_cacheable");
        end else begin
            check(tag, {31'd0, hit}, 1, "hit");
            check(tag, {26'd0, cs_n}, 32'h3F & ~(32'd1 << win), "cs_n");
            check(tag, {29'd0, sel_idx}, win, "sel_idx");
            check(tag, {30'd0, sel_bw}, m_bw[win], "sel_bw");
            check(tag, {31'd0, sel_cacheable}, m_nc[win] == 0, "sel_cacheable");
        end
    endtask

    // one clock: drive at negedge, check read data, capture, check decode
    task automatic step(input bit we, input int ofs, input logic [31:0] d,
                        input bit v, input logic [31:0] a, input string tag);
        reg_wr_en = we; reg_ofs = 6'(ofs); reg_wdata = d;
        bus_valid = v;  bus_addr = a;
        #1;
        check(tag, reg_rdata, model_read(ofs), "reg_rdata");
        @(posedge clk);
        if (we) model_write(ofs, d);
        @(negedge clk);
        expect_outputs(tag, v, a);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; reg_wr_en = 0; bus_valid = 0;
        model_reset();
        @(negedge clk);
        check("R1", {26'd0, cs_n}, 32'h3F, "cs_n in reset");
        check("R1", {31'd0, hit}, 0, "hit in reset");
        rst_n = 1;
    endtask

    initial begin
        model_reset();
        do_reset();
        // reset readback
        for (int o = 0; o < 48; o += 4) step(0, o, 0, 0, 0, (o < 8) ? "R8" : "R10");
        // boot region live from reset
        step(0, 0, 0, 1, 32'h0000_1234, "R8");
        step(0, 0, 0, 1, 32'h0001_0000, "R6");
        step(1, 0, 32'hFFFF_FFF6, 0, 0, "R8");
        step(0, 0, 0, 1, 32'h0000_FFF0, "R8");
        // half programmed region 1: base only
        step(1, 8, 32'h4000_0002, 0, 0, "R4");
        step(0, 8, 0, 1, 32'h4000_0000, "R4");
        step(1, 12, 32'h0000_0FF0, 0, 0, "R3");
        step(0, 12, 0, 1, 32'h4000_0AB0, "R2");
        step(0, 0, 0, 1, 32'h4000_1000, "R2");
        step(0, 0, 0, 1, 32'h4000_000C, "R2");
        // half programmed region 2: mask only
        step(1, 20, 32'h00FF_FFF0, 0, 0, "R4");
        step(0, 0, 0, 1, 32'h8000_0040, "R4");
        step(1, 16, 32'h8000_0001, 0, 0, "R3");
        step(0, 16, 0, 1, 32'h80AB_0040, "R7");
        // overlap: region 3 covers region 1
        step(1, 24, 32'h4000_0004, 0, 0, "R3");
        step(1, 28, 32'h0FFF_FFF0, 0, 0, "R3");
        step(0, 24, 0, 1, 32'h4000_0100, "R5");
        step(0, 28, 0, 1, 32'h4100_0000, "R7");
        // ignored writes
        step(1, 9, 32'hFFFF_FFFF, 0, 0, "R9");
        step(0, 8, 0, 1, 32'h4000_0AB0, "R9");
        step(1, 48, 32'hFFFF_FFFF, 0, 0, "R9");
        step(0, 48, 0, 0, 0, "R9");
        step(0, 62, 0, 0, 0, "R9");
        // invalid phase
        step(0, 0, 0, 0, 32'h4000_0AB0, "R1");
        // region 4 and 5, then a sweep
        step(1, 32, 32'hC000_0006, 0, 0, "R3");
        step(1, 36, 32'h0000_FFF0, 0, 0, "R3");
        step(1, 40, 32'hD000_0000, 0, 0, "R3");
        step(1, 44, 32'h0000_0000, 0, 0, "R3");
        for (int k = 0; k < 40; k++) begin
            logic [31:0] a;
            a = {k[1:0] == 0 ? 4'hC : k[1:0] == 1 ? 4'hD : k[1:0] == 2 ? 4'h4 : 4'h0,
                 k[5:2] ^ 4'h0, 8'h00, k[3:0], 8'h00};
            if (k % 5 == 0) a = 32'hD000_0004 + k;
            step(0, (k % 12) * 4, 0, (k % 7) != 3, a, "R2");
        end
        // reset clears written status
        do_reset();
        step(0, 8, 0, 1, 32'h4000_0AB0, "R10");
        step(0, 12, 0, 1, 32'h0000_0010, "R10");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule